// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block is the host-side master for a three-wire serial DAC bus. A client hands it one request at a time: a 2-bit device select, a 2-bit output channel and an 8-bit conversion code, offered with a valid/ready handshake. The block packs these into a 12-bit word and clocks it out most significant bit first. The serial clock is derived from the system clock by counting cycles. After the last bit, the block raises the latch strobe, waits out the hold time and signals completion with a one-cycle pulse.

A separate command drives the device's active-low reset line for a programmed time. The block then keeps the bus quiet for a recovery interval. If the command arrives while a word is in flight, it is remembered and carried out once that word is complete. Every timing minimum of the device is a parameter counted in whole system-clock cycles. The integrator chooses each value so that it covers the nanosecond limit at the clock frequency in use.

All outputs come straight from flip-flops. Reset is synchronous and active high.

Top module: `dac_frame_tx`

## Requirements
- R1: The word sent is {sel[1:0], chan[1:0], code[7:0]}, 12 bits, MSB first. One bit is taken per rising edge of `sclk`. `sdata` changes only while `sclk` is low and never in the cycle `sclk` rises. `sclk` rests low between words.
- R2: During a word, each high phase and each low phase of `sclk` lasts exactly HALF_CYC system cycles.
- R3: `latch` rises exactly HALF_CYC + SETUP_CYC cycles after the last rising edge of `sclk` in a word.
- R4: `latch` stays high for exactly STROBE_CYC cycles, and `sclk` is low for the whole strobe.
- R5: `req_ready` is low from the cycle after acceptance until the word ends. `done` is a single-cycle pulse, HOLD_CYC cycles after `latch` falls. With no reset command pending, `req_ready` is high in that same cycle.
- R6: A request is taken at the clock edge where `req_valid` and `req_ready` are both high. Its fields are captured at that edge, and later changes to the request inputs do not alter the word on the wire.
- R7: A reset command (`rst_cmd` high for one cycle) drives `dac_rst_n` low for exactly RLOW_CYC cycles. After release, `req_ready` stays low and no strobe occurs for exactly RWAIT_CYC cycles.
- R8: A reset command received during a word is held. `dac_rst_n` stays high until that word's `done`, and goes low in the next cycle.
- R9: While `rst` is high, `sclk`, `latch`, `done` and `req_ready` are 0 and `dac_rst_n` is 1. `req_ready` rises in the first cycle after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_sel | input | 2 | Device select field |
| req_chan | input | 2 | Output channel field |
| req_code | input | 8 | Conversion code |
| rst_cmd | input | 1 | Pulse to request a device reset |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock to the device |
| sdata | output | 1 | Serial data to the device |
| latch | output | 1 | Load strobe, active high |
| dac_rst_n | output | 1 | Device reset, active low |

## Verification
Several properties are checked in every cycle:
- data never moves while the serial clock is high or just rising;
- the clock is low and steady across the strobe;
- each clock high phase has the programmed length;
- the handshake is closed whenever the bus is busy or the reset line is low;
- `done` lasts a single cycle.

Other behaviour is only visible across a whole scenario, so the bench covers it:
- the bit order and content of each word;
- the exact spacing from the last clock edge to the strobe, and from the strobe to `done`;
- the reset pulse length and recovery interval;
- deferral of a reset command raised mid-word;
- a request that is left waiting during recovery.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LO    = 3'd1,
    ST_HI    = 3'd2,
    ST_SETUP = 3'd3,
    ST_STRB  = 3'd4,
    ST_HOLD  = 3'd5,
    ST_RLOW  = 3'd6,
    ST_RWAIT = 3'd7
  } tx_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned a);
    return (a < 1) ? 1 : a;
  endfunction

endpackage

// File: rtl/dac_tx_timer.sv
module dac_tx_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] value,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= value;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/dac_tx_shifter.sv
module dac_tx_shifter #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] word,
  input  logic             shift,
  output logic             msb
);

  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= word;
    end else if (shift) begin
      sr_q <= {sr_q[WIDTH-2:0], 1'b0};
    end
  end

  assign msb = sr_q[WIDTH-1];

endmodule

// File: rtl/dac_tx_seq.sv
module dac_tx_seq
  import dac_tx_pkg::*;
#(
  parameter int FRAME_W    = 12,
  parameter int HALF_CYC   = 3,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 2,
  parameter int RLOW_CYC   = 5,
  parameter int RWAIT_CYC  = 5,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             rst_cmd,
  input  logic             t_zero,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             sh_load,
  output logic             sh_shift,
  output logic             req_ready,
  output logic             done,
  output logic             sclk,
  output logic             latch,
  output logic             dac_rst_n
);

  localparam int BIT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] HALF_V   = CNT_W'(at_least_one(HALF_CYC) - 1);
  localparam logic [CNT_W-1:0] SETUP_V  = CNT_W'(at_least_one(SETUP_CYC) - 1);
  localparam logic [CNT_W-1:0] STROBE_V = CNT_W'(at_least_one(STROBE_CYC) - 1);
  localparam logic [CNT_W-1:0] HOLD_V   = CNT_W'(at_least_one(HOLD_CYC) - 1);
  localparam logic [CNT_W-1:0] RLOW_V   = CNT_W'(at_least_one(RLOW_CYC) - 1);
  localparam logic [CNT_W-1:0] RWAIT_V  = CNT_W'(at_least_one(RWAIT_CYC) - 1);

  tx_state_t        st_q, st_n;
  logic [BIT_W-1:0] bits_q, bits_n;
  logic             pend_q, pend_n, pend_clr;
  logic             accept;

  assign accept = req_valid & req_ready;

  always_comb begin
    st_n     = st_q;
    bits_n   = bits_q;
    t_load   = 1'b0;
    t_val    = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    pend_clr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_q) begin
          st_n     = ST_RLOW;
          t_load   = 1'b1;
          t_val    = RLOW_V;
          pend_clr = 1'b1;
        end else if (accept) begin
          st_n    = ST_LO;
          t_load  = 1'b1;
          t_val   = HALF_V;
          sh_load = 1'b1;
          bits_n  = LAST_BIT;
        end
      end
      ST_LO: begin
        if (t_zero) begin
          st_n   = ST_HI;
          t_load = 1'b1;
          t_val  = HALF_V;
        end
      end
      ST_HI: begin
        if (t_zero) begin
          t_load = 1'b1;
          if (bits_q == '0) begin
            st_n  = ST_SETUP;
            t_val = SETUP_V;
          end else begin
            st_n     = ST_LO;
            t_val    = HALF_V;
            sh_shift = 1'b1;
            bits_n   = bits_q - 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (t_zero) begin
          st_n   = ST_STRB;
          t_load = 1'b1;
          t_val  = STROBE_V;
        end
      end
      ST_STRB: begin
        if (t_zero) begin
          st_n   = ST_HOLD;
          t_load = 1'b1;
          t_val  = HOLD_V;
        end
      end
      ST_HOLD: begin
        if (t_zero) st_n = ST_IDLE;
      end
      ST_RLOW: begin
        if (t_zero) begin
          st_n   = ST_RWAIT;
          t_load = 1'b1;
          t_val  = RWAIT_V;
        end
      end
      ST_RWAIT: begin
        if (t_zero) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    pend_n = pend_clr ? rst_cmd : (pend_q | rst_cmd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bits_q    <= '0;
      pend_q    <= 1'b0;
      req_ready <= 1'b0;
      done      <= 1'b0;
      sclk      <= 1'b0;
      latch     <= 1'b0;
      dac_rst_n <= 1'b1;
    end else begin
      st_q      <= st_n;
      bits_q    <= bits_n;
      pend_q    <= pend_n;
      req_ready <= (st_n == ST_IDLE) && !pend_n;
      done      <= (st_q == ST_HOLD) && (st_n == ST_IDLE);
      sclk      <= (st_n == ST_HI);
      latch     <= (st_n == ST_STRB);
      dac_rst_n <= (st_n != ST_RLOW);
    end
  end

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_tx_pkg::*;
#(
  parameter int SEL_W      = 2,
  parameter int CHAN_W     = 2,
  parameter int CODE_W     = 8,
  parameter int HALF_CYC   = 3,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 2,
  parameter int RLOW_CYC   = 5,
  parameter int RWAIT_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              rst_cmd,
  output logic              done,
  output logic              sclk,
  output logic              sdata,
  output logic              latch,
  output logic              dac_rst_n
);

  localparam int FRAME_W = SEL_W + CHAN_W + CODE_W;
  localparam int MAX_DUR = max2(max2(max2(HALF_CYC, SETUP_CYC), max2(STROBE_CYC, HOLD_CYC)),
                                max2(RLOW_CYC, RWAIT_CYC));
  localparam int CNT_W   = $clog2(MAX_DUR + 1);

  logic [FRAME_W-1:0] word;
  logic               t_load, t_zero, sh_load, sh_shift;
  logic [CNT_W-1:0]   t_val;

  assign word = {req_sel, req_chan, req_code};

  dac_tx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (t_load),
    .value (t_val),
    .zero  (t_zero)
  );

  dac_tx_shifter #(.WIDTH(FRAME_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .word  (word),
    .shift (sh_shift),
    .msb   (sdata)
  );

  dac_tx_seq #(
    .FRAME_W    (FRAME_W),
    .HALF_CYC   (HALF_CYC),
    .SETUP_CYC  (SETUP_CYC),
    .STROBE_CYC (STROBE_CYC),
    .HOLD_CYC   (HOLD_CYC),
    .RLOW_CYC   (RLOW_CYC),
    .RWAIT_CYC  (RWAIT_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rst_cmd   (rst_cmd),
    .t_zero    (t_zero),
    .t_load    (t_load),
    .t_val     (t_val),
    .sh_load   (sh_load),
    .sh_shift  (sh_shift),
    .req_ready (req_ready),
    .done      (done),
    .sclk      (sclk),
    .latch     (latch),
    .dac_rst_n (dac_rst_n)
  );

endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk #(
  parameter int HALF_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic done,
  input logic sclk,
  input logic sdata,
  input logic latch,
  input logic dac_rst_n
);

  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= '0;
    else if (sclk) hi_run <= hi_run + 16'd1;
    else hi_run <= '0;
  end

  a_r1_data_still_while_high: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(sdata));

  a_r1_data_still_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdata));

  a_r2_high_phase_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_run == 16'(HALF_CYC)));

  a_r4_clk_low_in_strobe: assert property (@(posedge clk) disable iff (rst)
    latch |-> !sclk);

  a_r4_clk_static_after_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(latch) |-> !sclk);

  a_r5_not_ready_when_busy: assert property (@(posedge clk) disable iff (rst)
    (sclk || latch || !dac_rst_n) |-> !req_ready);

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_bus_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    !dac_rst_n |-> (!latch && !sclk));

endmodule

bind dac_frame_tx dac_frame_tx_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .done      (done),
  .sclk      (sclk),
  .sdata     (sdata),
  .latch     (latch),
  .dac_rst_n (dac_rst_n)
);

// File: tb/test_dac_frame_tx.sv
module test_dac_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 3;
  localparam int SETUP = 2;
  localparam int STRB  = 2;
  localparam int HOLD  = 2;
  localparam int RLOW  = 5;
  localparam int RWAIT = 5;
  localparam int NVEC  = 6;

  // {sel, chan, code, expected 12-bit word}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd0, 2'd0, 8'h00, 12'h000},
    {2'd3, 2'd3, 8'hFF, 12'hFFF},
    {2'd2, 2'd1, 8'hA5, 12'h9A5},
    {2'd1, 2'd2, 8'h3C, 12'h63C},
    {2'd0, 2'd3, 8'h81, 12'h381},
    {2'd3, 2'd0, 8'h7E, 12'hC7E}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_sel = '0;
  logic [1:0] req_chan = '0;
  logic [7:0] req_code = '0;
  logic rst_cmd = 1'b0;
  logic req_ready, done, sclk, sdata, latch, dac_rst_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [11:0] exp_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_frame_tx #(
    .HALF_CYC(HALF), .SETUP_CYC(SETUP), .STROBE_CYC(STRB),
    .HOLD_CYC(HOLD), .RLOW_CYC(RLOW), .RWAIT_CYC(RWAIT)
  ) i_dac_frame_tx (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_chan(req_chan), .req_code(req_code),
    .rst_cmd(rst_cmd), .done(done), .sclk(sclk), .sdata(sdata),
    .latch(latch), .dac_rst_n(dac_rst_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
               req, act, act, expv, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Bus monitor, sampling at falling edges of the system clock
  logic        p_sclk = 0, p_latch = 0, p_rstn = 1;
  int          run = 0, bits = 0, since_rise = 0, lrun = 0, since_lf = 0;
  int          rrun = 0, since_rst = 1000;
  bit          in_word = 0, lf_armed = 0, rst_armed = 0, rst_seen = 0;
  logic [11:0] cap = '0;

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = 0; p_latch = 0; p_rstn = 1; run = 0; bits = 0; in_word = 0;
      lf_armed = 0; rst_armed = 0;
    end else begin
      since_rise++; since_lf++; since_rst++;
      if (sclk != p_sclk) begin
        if (!sclk) chk(run == HALF, "R2 high phase", run, HALF);
        else if (in_word) chk(run == HALF, "R2 low phase", run, HALF);
        run = 1;
      end else run++;
      if (sclk && !p_sclk) begin
        chk(!$isunknown(sdata), "R1 data known at rise", 0, 0);
        cap = {cap[10:0], sdata};
        bits++; since_rise = 0; in_word = 1;
      end
      if (latch && !p_latch) begin
        chk(bits == 12, "R1 bit count", bits, 12);
        chk(cap == exp_word, "R1 word content", cap, exp_word);
        chk(since_rise == HALF + SETUP, "R3 rise-to-strobe", since_rise, HALF + SETUP);
        chk(!sclk, "R4 clock low at strobe", sclk, 0);
        if (rst_seen) chk(since_rst >= RWAIT, "R7 strobe after recovery", since_rst, RWAIT);
        bits = 0; in_word = 0; lrun = 1;
      end else if (latch) lrun++;
      if (!latch && p_latch) begin
        chk(lrun == STRB, "R4 strobe width", lrun, STRB);
        since_lf = 0; lf_armed = 1;
      end
      if (done) begin
        chk(lf_armed && since_lf == HOLD, "R5 hold before done", since_lf, HOLD);
        lf_armed = 0;
      end
      if (!dac_rst_n && p_rstn) rrun = 1;
      else if (!dac_rst_n) rrun++;
      if (dac_rst_n && !p_rstn) begin
        chk(rrun == RLOW, "R7 reset pulse width", rrun, RLOW);
        since_rst = 0; rst_armed = 1; rst_seen = 1;
      end
      if (rst_armed && req_ready) begin
        chk(since_rst == RWAIT, "R7 recovery length", since_rst, RWAIT);
        rst_armed = 0;
      end
      p_sclk = sclk; p_latch = latch; p_rstn = dac_rst_n;
    end
  end

  task automatic issue(input logic [1:0] s, input logic [1:0] c, input logic [7:0] d,
                       input logic [11:0] e);
    @(negedge clk);
    exp_word  = e;
    req_sel   = s; req_chan = c; req_code = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R5 ready low after accept", req_ready, 0);
    req_sel = ~s; req_chan = ~c; req_code = ~d;  // R6: changes after acceptance
  endtask

  task automatic wait_done(input bit expect_ready);
    while (!done) @(negedge clk);
    if (expect_ready) chk(req_ready == 1'b1, "R5 ready with done", req_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", done, 0);
  endtask

  task automatic pulse_rst_cmd();
    @(negedge clk);
    rst_cmd = 1'b1;
    @(negedge clk);
    rst_cmd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0 (run hung)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk(sclk == 0, "R9 sclk in reset", sclk, 0);
    chk(latch == 0, "R9 latch in reset", latch, 0);
    chk(done == 0, "R9 done in reset", done, 0);
    chk(req_ready == 0, "R9 ready in reset", req_ready, 0);
    chk(dac_rst_n == 1, "R9 dac_rst_n in reset", dac_rst_n, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1, "R9 ready after release", req_ready, 1);

    // Table walk: R1..R6
    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][23:22], VEC[i][21:20], VEC[i][19:12], VEC[i][11:0]);
      wait_done(1'b1);
    end

    // R7: reset command in idle, then a request waiting through recovery
    pulse_rst_cmd();
    @(negedge clk);
    chk(dac_rst_n == 0, "R7 reset line low", dac_rst_n, 0);
    issue(2'd1, 2'd1, 8'h5A, 12'h55A);
    wait_done(1'b1);

    // R8: reset command raised mid-word is deferred
    issue(2'd2, 2'd2, 8'hC3, 12'hAC3);
    repeat (10) @(negedge clk);
    pulse_rst_cmd();
    while (!done) begin
      chk(dac_rst_n == 1, "R8 reset held during word", dac_rst_n, 1);
      @(negedge clk);
    end
    chk(req_ready == 0, "R8 ready low with pending reset", req_ready, 1'b0);
    @(negedge clk);
    chk(dac_rst_n == 0, "R8 reset after done", dac_rst_n, 0);
    while (!req_ready) @(negedge clk);

    // back-to-back words after recovery
    issue(2'd3, 2'd1, 8'h01, 12'hD01);
    wait_done(1'b1);
    issue(2'd0, 2'd2, 8'h80, 12'h280);
    wait_done(1'b1);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule